// File: doc/BRIEF.md
# Searchable FIFO with Flush

This block is a synchronous first-in first-out queue. Each entry carries a register index, a flag that says whether the entry writes that register, and a payload. The queue also has a combinational lookup port. A pipeline stage can present a register index on this port and learn, in the same cycle, whether any queued entry is still going to write that register. When several queued entries match, the port returns the youngest of them, which is the one that would be the last writer.

Storage is a ring of DEPTH+1 slots addressed by a read pointer and a write pointer. The write pointer always names the free slot that the next push will fill. Because one slot is always kept free, equal pointers mean empty, and a write pointer one step behind the read pointer means full. A flush input discards every entry in a single cycle. Redirect logic can use it to kill all work in flight.

Top module: `srch_fifo`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `find_hit`=0.
- R2: The queue holds exactly DEPTH entries. `full` rises after DEPTH accepted pushes with no pop, and `empty` is 1 exactly when no entry is held. `full` and `empty` are never both 1.
- R3: `first_data` shows the oldest held entry. Entries leave in the order they were pushed, and `first_data` stays unchanged while no pop or flush occurs.
- R4: A push while `full`=1 is ignored, and the held contents stay unchanged.
- R5: A pop while `empty`=1 is ignored. The queue stays empty, and a later push is still the first entry out.
- R6: A push and a pop in the same cycle on a queue that is neither empty nor full both take effect. The entry count is unchanged and order is preserved.
- R7: `clr`=1 empties the queue by the next cycle. It takes priority over a push or pop in the same cycle, so neither of those takes effect.
- R8: The entry layout is: bit EW-1 is the writes-register flag, bits EW-2 down to PAY_W are the register index, and bits PAY_W-1 down to 0 are the payload. `find_hit`=1 exactly when some held entry has flag 1 and an index equal to `find_key`. `find_data` is then the most recently pushed such entry.
- R9: Slots that are not between the read and write pointers are never reported. Entries that were popped or flushed cannot produce a hit.
- R10: The lookup reflects only the entries held at the start of the cycle. An entry pushed in the same cycle is not visible until the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Push request |
| enq_data | input | EW | Entry to push (flag, index, payload) |
| full | output | 1 | Queue holds DEPTH entries |
| deq_en | input | 1 | Pop request |
| first_data | output | EW | Oldest held entry |
| empty | output | 1 | Queue holds no entries |
| clr | input | 1 | Flush all entries |
| find_key | input | IDX_W | Register index to look up |
| find_hit | output | 1 | Some held entry writes `find_key` |
| find_data | output | EW | Youngest matching entry |

## Verification
Some properties are checked by assertions on every cycle:
- `full` and `empty` are exclusive, and both pointers stay inside the ring.
- A flush always leaves the queue empty, and idle full or empty states persist.
- The head entry stays stable when nothing is popped.
- Any reported hit carries the set flag and the requested index.

Other behaviours can only be shown by bench scenarios. These are that the youngest of several matching entries is returned rather than an older one, that popped or flushed slots whose stale contents still match are not reported, that a same-cycle push is not visible to the lookup, and that order survives wrap-around of the ring.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
   // Modular step on a ring of the given size; delta may be negative.
   function automatic int ring_step(int p, int slots, int delta);
      return (p + delta + 2 * slots) % slots;
   endfunction
endpackage

// File: rtl/sfifo_ptr.sv
module sfifo_ptr #(
   parameter int SLOTS = 5,
   localparam int PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          load,
   input  logic [PW-1:0] load_val,
   output logic [PW-1:0] ptr
);
   logic [PW-1:0] nxt;

   generate
      if ((1 << PW) == SLOTS) begin : g_pow2
         assign nxt = ptr + 1'b1;
      end else begin : g_wrap
         assign nxt = (ptr == PW'(SLOTS - 1)) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (adv)  ptr <= nxt;
   end

   AST_PTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr) < SLOTS); // R2
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
   parameter int SLOTS = 5,
   parameter int EW    = 22,
   localparam int PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [PW-1:0]            waddr,
   input  logic [EW-1:0]            wdata,
   output logic [SLOTS-1:0][EW-1:0] mem_o
);
   logic [SLOTS-1:0][EW-1:0] mem_q;

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign mem_o = mem_q;
endmodule

// File: rtl/sfifo_search.sv
module sfifo_search #(
   parameter int SLOTS = 5,
   parameter int IDX_W = 5,
   parameter int PAY_W = 16,
   localparam int EW   = 1 + IDX_W + PAY_W,
   localparam int PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic [SLOTS-1:0][EW-1:0] mem,
   input  logic [PW-1:0]            head,
   input  logic [PW-1:0]            tail,
   input  logic [IDX_W-1:0]         key,
   output logic                     hit,
   output logic [EW-1:0]            data
);
   int live;

   always_comb begin
      live = sfifo_pkg::ring_step(int'(tail), SLOTS, -int'(head));
      hit  = 1'b0;
      data = '0;
      // age 0 is the youngest entry; scan oldest first so the youngest wins
      for (int age = SLOTS - 2; age >= 0; age--) begin
         int idx;
         idx = sfifo_pkg::ring_step(int'(tail), SLOTS, -1 - age);
         if (age < live && mem[idx[PW-1:0]][EW-1] &&
             mem[idx[PW-1:0]][EW-2:PAY_W] == key) begin
            hit  = 1'b1;
            data = mem[idx[PW-1:0]];
         end
      end
   end
endmodule

// File: rtl/srch_fifo.sv
module srch_fifo #(
   parameter int DEPTH = 4,
   parameter int IDX_W = 5,
   parameter int PAY_W = 16,
   localparam int EW    = 1 + IDX_W + PAY_W,
   localparam int SLOTS = DEPTH + 1,
   localparam int PW    = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enq_valid,
   input  logic [EW-1:0]    enq_data,
   output logic             full,
   input  logic             deq_en,
   output logic [EW-1:0]    first_data,
   output logic             empty,
   input  logic             clr,
   input  logic [IDX_W-1:0] find_key,
   output logic             find_hit,
   output logic [EW-1:0]    find_data
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("srch_fifo: DEPTH must be at least 1");
      end
      if (IDX_W < 1 || PAY_W < 1) begin : g_bad_width
         $error("srch_fifo: IDX_W and PAY_W must be positive");
      end
   endgenerate

   logic [PW-1:0]            head, tail, tail_inc;
   logic [SLOTS-1:0][EW-1:0] mem;
   logic                     enq_go, deq_go;

   assign tail_inc = PW'(sfifo_pkg::ring_step(int'(tail), SLOTS, 1));
   assign empty    = (tail == head);
   assign full     = (tail_inc == head);
   assign enq_go   = enq_valid && !full  && !clr;
   assign deq_go   = deq_en    && !empty && !clr;

   sfifo_ptr #(.SLOTS(SLOTS)) u_head (
      .clk(clk), .rst_n(rst_n), .adv(deq_go), .load(1'b0),
      .load_val('0), .ptr(head));

   sfifo_ptr #(.SLOTS(SLOTS)) u_tail (
      .clk(clk), .rst_n(rst_n), .adv(enq_go), .load(clr),
      .load_val(head), .ptr(tail));

   sfifo_store #(.SLOTS(SLOTS), .EW(EW)) u_store (
      .clk(clk), .we(enq_go), .waddr(tail), .wdata(enq_data), .mem_o(mem));

   sfifo_search #(.SLOTS(SLOTS), .IDX_W(IDX_W), .PAY_W(PAY_W)) u_search (
      .mem(mem), .head(head), .tail(tail), .key(find_key),
      .hit(find_hit), .data(find_data));

   assign first_data = mem[head];

   AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R2
   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      full && !deq_en && !clr |=> full); // R4
   AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      empty && !enq_valid |=> empty); // R5
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty); // R7
   AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !empty && !deq_en && !clr |=> $stable(first_data)); // R3
   AST_HIT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      find_hit |-> find_data[EW-1] && find_data[EW-2:PAY_W] == find_key); // R8
   AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !find_hit); // R9
endmodule

// File: tb/tb_srch_fifo.sv
module tb_srch_fifo;
   localparam int DEPTH = 4;
   localparam int IDX_W = 5;
   localparam int PAY_W = 16;
   localparam int EW    = 1 + IDX_W + PAY_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enq_valid = 1'b0, deq_en = 1'b0, clr = 1'b0;
   logic [EW-1:0]    enq_data = '0;
   logic [IDX_W-1:0] find_key = '0;
   logic             full, empty, find_hit;
   logic [EW-1:0]    first_data, find_data;

   int checks = 0;
   int errors = 0;
   logic [EW-1:0] model[$];

   always #2 clk = ~clk;

   srch_fifo #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PAY_W(PAY_W)) dut (
      .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_data(enq_data),
      .full(full), .deq_en(deq_en), .first_data(first_data), .empty(empty),
      .clr(clr), .find_key(find_key), .find_hit(find_hit), .find_data(find_data));

   function automatic logic [EW-1:0] mk(bit w, int idx, int pay);
      return {w, IDX_W'(idx), PAY_W'(pay)};
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Expected lookup: youngest entry with flag set and matching index
   function automatic logic [EW:0] exp_find(logic [IDX_W-1:0] k);
      for (int i = model.size() - 1; i >= 0; i--)
         if (model[i][EW-1] && model[i][EW-2:PAY_W] == k) return {1'b1, model[i]};
      return '0;
   endfunction

   task automatic step(bit e, logic [EW-1:0] d, bit dq, bit c,
                       logic [IDX_W-1:0] k, string tag);
      logic [EW:0] f;
      bit eg, dg;
      @(negedge clk);
      enq_valid = e; enq_data = d; deq_en = dq; clr = c; find_key = k;
      #1;
      f = exp_find(k);
      chk({tag, " R2 empty"}, 64'(empty), 64'(model.size() == 0));
      chk({tag, " R2 full"},  64'(full),  64'(model.size() == DEPTH));
      if (model.size() > 0) chk({tag, " R3 first_data"}, 64'(first_data), 64'(model[0]));
      chk({tag, " R8 find_hit"}, 64'(find_hit), 64'(f[EW]));
      if (f[EW]) chk({tag, " R8 find_data"}, 64'(find_data), 64'(f[EW-1:0]));
      @(posedge clk);
      if (c) model.delete();
      else begin
         dg = dq && model.size() > 0;
         eg = e && model.size() < DEPTH;
         if (dg) void'(model.pop_front());
         if (eg) model.push_back(d);
      end
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(20240611);
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 empty after reset", 64'(empty), 64'd1);
      chk("R1 full after reset", 64'(full), 64'd0);
      chk("R1 no hit after reset", 64'(find_hit), 64'd0);

      // R5: pop on empty ignored
      step(0, '0, 1, 0, 5'd3, "R5");
      step(1, mk(1, 3, 16'h0a01), 0, 0, 5'd3, "R10 same-cycle push hidden");
      step(0, '0, 0, 0, 5'd3, "R10 visible next cycle");
      // fill to full with duplicates of index 3
      step(1, mk(0, 3, 16'h0a02), 0, 0, 5'd3, "R8");
      step(1, mk(1, 3, 16'h0a03), 0, 0, 5'd3, "R8");
      step(1, mk(1, 7, 16'h0a04), 0, 0, 5'd3, "R2 fill");
      step(1, mk(1, 3, 16'h0bad), 0, 0, 5'd3, "R4 push on full");
      step(0, '0, 0, 0, 5'd7, "R4 contents kept");
      step(1, mk(1, 9, 16'h0a05), 1, 0, 5'd3, "R4 push ignored pop taken");
      step(1, mk(1, 9, 16'h0a06), 1, 0, 5'd9, "R6 push and pop");
      step(0, '0, 1, 0, 5'd3, "R9 popped not seen");
      step(0, '0, 1, 0, 5'd3, "R9");
      step(0, '0, 0, 0, 5'd9, "R6 order kept");
      step(1, mk(1, 9, 16'h0a07), 1, 1, 5'd9, "R7 clear wins");
      step(0, '0, 0, 0, 5'd9, "R7 R9 flushed not seen");
      step(0, '0, 1, 0, 5'd9, "R5 pop after clear");

      // constrained random, small index range for frequent matches
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = $urandom_range(0, 99);
         step($urandom_range(0, 99) < 60,
              mk($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 65535)),
              $urandom_range(0, 99) < 45, r < 3,
              IDX_W'($urandom_range(0, 3)), "rand R3 R8 R9");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule